// File: doc/BRIEF.md
# Debug-Bus Multi-Port Serial Mailbox

This block connects a debugger and a processor core through a set of virtual serial channels. The debugger reaches it through three 32-bit registers on a small request/response debug bus: a control/status word, a send register and a receive register. The core reaches each channel through two valid/ready streams. On one stream the core drains words the debugger sent. On the other stream the core feeds words for the debugger to collect. Each channel owns one 4-entry queue in each direction.

A channel-select field in the control word chooses which channel the send and receive registers reach. The control word shows the status of every channel at once. Any access that would overflow or underflow a queue is refused with an error response. That access also latches a per-channel sticky error flag, and while the flag is set every data access to that channel is refused. The debugger clears the flag by writing 1 to it.

The debug bus takes one access per request cycle and answers exactly one cycle later. The core-side streams follow the usual rules: a word moves on a cycle where valid and ready are both high. A producer holding valid low-ready keeps its data unchanged until the transfer happens.

Top module: `dbg_serial_mailbox`

## Requirements
- R1: After reset the channel select is 0, every channel's error, pending and full flags are 0, no core-side receive stream is valid, and every core-side feed stream is ready.
- R2: The control/status word (address 0x34) holds the channel count in bits [31:24] and the channel select in bits [23:16]. For channel n it holds the error flag at bit 3n, the pending flag at bit 3n+1 and the full flag at bit 3n+2. A write whose select value is not below the channel count leaves the select unchanged.
- R3: A write to the send register (0x35) whose channel has a clear error flag and a non-full outbound queue is answered without error. The word is appended to that channel's outbound queue, and the core side receives the queued words in write order.
- R4: The outbound queue holds 4 words, and its full flag is 1 while all 4 are occupied. A send write while the queue is full, or while the error flag is set, is answered with an error. That write appends nothing and sets the channel's error flag.
- R5: A read of the send register returns the value of the latest write to it, whether that write was accepted or refused, and is answered without error.
- R6: A read of the receive register (0x36) whose channel has a clear error flag and a non-empty inbound queue returns the oldest inbound word without error and removes it. The pending flag is 1 exactly while the inbound queue is non-empty.
- R7: A receive read while the inbound queue is empty, or while the error flag is set, is answered with an error and read data 0. It sets the error flag and leaves the inbound queue unchanged.
- R8: An error flag stays set until a control/status write has a 1 in that flag's bit position. Writing 0 there has no effect.
- R9: The receive register is read-only. A write to it is answered with an error and changes no queue and no error flag.
- R10: Every request gets exactly one response, valid in the cycle after the request. A request to any address other than 0x34 to 0x36 is answered with an error and read data 0.
- R11: A core-side receive stream is valid while that channel's outbound queue is non-empty and holds its data stable until ready. A core-side feed stream is ready while that channel's inbound queue has a free entry.
- R12: With a channel count of 0, none of the three registers exists, and every access is answered with an error.
- R13: Send and receive accesses affect only the selected channel's queues and error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Debug-bus access request, one per cycle |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 7 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| bus_rdata_o | output | 32 | Read data, 0 on error |
| bus_err_o | output | 1 | Error response |
| core_rx_valid_o | output | NUM_PORTS | Per-channel debugger-to-core word valid |
| core_rx_ready_i | input | NUM_PORTS | Per-channel core ready to take a word |
| core_rx_data_o | output | NUM_PORTS*DATA_W | Per-channel debugger-to-core word |
| core_tx_valid_i | input | NUM_PORTS | Per-channel core word valid |
| core_tx_ready_o | output | NUM_PORTS | Per-channel space available for a core word |
| core_tx_data_i | input | NUM_PORTS*DATA_W | Per-channel core-to-debugger word |

## Verification
The assertions assume that the core keeps a stream's valid and data steady while ready is low. They also assume that a bus request lasts one cycle per access. The bench drives each core handshake for a single cycle at a time, taking data only after it has seen ready or valid. Bus requests are driven in one-cycle pulses separated by an idle cycle, so no access overlaps another. A second instance built with zero channels shares the bus inputs, so every access also exercises the case where no registers exist.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int REG_W  = 32;
  localparam int BUS_AW = 7;

  // Register addresses (fixed by the debug bus map)
  localparam logic [BUS_AW-1:0] ADR_CTRL = 7'h34;
  localparam logic [BUS_AW-1:0] ADR_SEND = 7'h35;
  localparam logic [BUS_AW-1:0] ADR_RECV = 7'h36;

  // Control/status word layout
  localparam int CH_STRIDE = 3;
  localparam int OFS_ERR   = 0;
  localparam int OFS_PEND  = 1;
  localparam int OFS_FULL  = 2;
  localparam int SEL_LSB   = 16;
  localparam int SEL_FW    = 8;
  localparam int CNT_LSB   = 24;
  localparam int MAX_CH    = 5;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_CTRL,
    ACC_SEND,
    ACC_RECV
  } acc_e;

  function automatic acc_e decode_addr(input logic [BUS_AW-1:0] a, input logic present);
    acc_e r;
    r = ACC_NONE;
    if (present) begin
      if (a == ADR_CTRL)      r = ACC_CTRL;
      else if (a == ADR_SEND) r = ACC_SEND;
      else if (a == ADR_RECV) r = ACC_RECV;
    end
    return r;
  endfunction

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          push, pop;

  assign in_ready_o  = (cnt_q != CW'(DEPTH));
  assign out_valid_o = (cnt_q != '0);
  assign out_data_o  = mem[rptr_q];
  assign push        = in_valid_i && in_ready_o;
  assign pop         = out_valid_o && out_ready_i;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wptr_q <= bump(wptr_q);
      if (pop)  rptr_q <= bump(rptr_q);
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem[wptr_q] <= in_data_i;
  end

  AST_FIFO_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= DEPTH); // R4

  AST_FIFO_HOLD_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))); // R11

endmodule

// File: rtl/mbx_port.sv
module mbx_port #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  // debugger side
  input  logic         send_req_i,
  input  logic [W-1:0] send_data_i,
  output logic         send_ok_o,
  input  logic         recv_req_i,
  output logic         recv_ok_o,
  output logic [W-1:0] recv_data_o,
  input  logic         err_clr_i,
  output logic         err_o,
  output logic         pend_o,
  output logic         full_o,
  // core side
  output logic         core_rx_valid_o,
  input  logic         core_rx_ready_i,
  output logic [W-1:0] core_rx_data_o,
  input  logic         core_tx_valid_i,
  output logic         core_tx_ready_o,
  input  logic [W-1:0] core_tx_data_i
);

  logic err_q;
  logic out_space;
  logic in_avail;

  assign send_ok_o = send_req_i && !err_q && out_space;
  assign recv_ok_o = recv_req_i && !err_q && in_avail;
  assign err_o     = err_q;
  assign pend_o    = in_avail;
  assign full_o    = !out_space;

  mbx_fifo #(.W(W), .DEPTH(DEPTH)) u_outq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (send_ok_o),
    .in_ready_o (out_space),
    .in_data_i  (send_data_i),
    .out_valid_o(core_rx_valid_o),
    .out_ready_i(core_rx_ready_i),
    .out_data_o (core_rx_data_o)
  );

  mbx_fifo #(.W(W), .DEPTH(DEPTH)) u_inq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (core_tx_valid_i),
    .in_ready_o (core_tx_ready_o),
    .in_data_i  (core_tx_data_i),
    .out_valid_o(in_avail),
    .out_ready_i(recv_ok_o),
    .out_data_o (recv_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
    end else if ((send_req_i && !send_ok_o) || (recv_req_i && !recv_ok_o)) begin
      err_q <= 1'b1;
    end else if (err_clr_i) begin
      err_q <= 1'b0;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !err_clr_i) |=> err_q); // R8

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(send_req_i || recv_req_i)); // R7

  AST_FULL_BLOCKS_SEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && send_req_i) |=> err_q); // R4

endmodule

// File: rtl/dbg_serial_mailbox.sv
module dbg_serial_mailbox
  import mbx_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 4,
  localparam int NP       = (NUM_PORTS > 0) ? NUM_PORTS : 1,
  localparam int SEL_W    = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_req_i,
  input  logic                 bus_we_i,
  input  logic [6:0]           bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic                 bus_rsp_valid_o,
  output logic [31:0]          bus_rdata_o,
  output logic                 bus_err_o,
  output logic [NP-1:0]        core_rx_valid_o,
  input  logic [NP-1:0]        core_rx_ready_i,
  output logic [NP*DATA_W-1:0] core_rx_data_o,
  input  logic [NP-1:0]        core_tx_valid_i,
  output logic [NP-1:0]        core_tx_ready_o,
  input  logic [NP*DATA_W-1:0] core_tx_data_i
);

  localparam logic PRESENT = (NUM_PORTS > 0);

  acc_e              acc;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] shadow_q;
  logic              ctrl_wr, send_wr, recv_rd;

  logic [NP-1:0]     send_req, send_ok, recv_req, recv_ok, err_clr;
  logic [NP-1:0]     err, pend, full;
  logic [NP-1:0]     prx_valid, ptx_ready;
  logic [DATA_W-1:0] recv_data [NP];

  logic [REG_W-1:0]  status;
  logic [DATA_W-1:0] recv_sel;
  logic [REG_W-1:0]  rdata_d;
  logic              err_d;

  assign acc     = bus_req_i ? decode_addr(bus_addr_i, PRESENT) : ACC_NONE;
  assign ctrl_wr = (acc == ACC_CTRL) && bus_we_i;
  assign send_wr = (acc == ACC_SEND) && bus_we_i;
  assign recv_rd = (acc == ACC_RECV) && !bus_we_i;

  // Per-channel queues and error flags
  for (genvar n = 0; n < NP; n++) begin : g_ch
    assign send_req[n] = send_wr && (sel_q == SEL_W'(n));
    assign recv_req[n] = recv_rd && (sel_q == SEL_W'(n));
    assign err_clr[n]  = ctrl_wr && bus_wdata_i[CH_STRIDE*n + OFS_ERR];

    mbx_port #(.W(DATA_W), .DEPTH(DEPTH)) u_ch (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .send_req_i     (send_req[n]),
      .send_data_i    (bus_wdata_i[DATA_W-1:0]),
      .send_ok_o      (send_ok[n]),
      .recv_req_i     (recv_req[n]),
      .recv_ok_o      (recv_ok[n]),
      .recv_data_o    (recv_data[n]),
      .err_clr_i      (err_clr[n]),
      .err_o          (err[n]),
      .pend_o         (pend[n]),
      .full_o         (full[n]),
      .core_rx_valid_o(prx_valid[n]),
      .core_rx_ready_i(core_rx_ready_i[n] && PRESENT),
      .core_rx_data_o (core_rx_data_o[n*DATA_W +: DATA_W]),
      .core_tx_valid_i(core_tx_valid_i[n] && PRESENT),
      .core_tx_ready_o(ptx_ready[n]),
      .core_tx_data_i (core_tx_data_i[n*DATA_W +: DATA_W])
    );

    assign core_rx_valid_o[n] = prx_valid[n] && PRESENT;
    assign core_tx_ready_o[n] = ptx_ready[n] && PRESENT;
  end

  // Control/status word assembly
  always_comb begin
    status = '0;
    status[CNT_LSB +: 8] = 8'(NUM_PORTS);
    status[SEL_LSB +: SEL_W] = sel_q;
    for (int n = 0; n < NP; n++) begin
      if (PRESENT && n < MAX_CH) begin
        status[CH_STRIDE*n + OFS_ERR]  = err[n];
        status[CH_STRIDE*n + OFS_PEND] = pend[n];
        status[CH_STRIDE*n + OFS_FULL] = full[n];
      end
    end
  end

  always_comb begin
    recv_sel = '0;
    for (int n = 0; n < NP; n++) begin
      if (sel_q == SEL_W'(n)) recv_sel = recv_data[n];
    end
  end

  // Response data and error
  always_comb begin
    rdata_d = '0;
    err_d   = 1'b0;
    unique case (acc)
      ACC_CTRL: begin
        if (!bus_we_i) rdata_d = status;
      end
      ACC_SEND: begin
        if (bus_we_i) err_d = !(|send_ok);
        else          rdata_d = REG_W'(shadow_q);
      end
      ACC_RECV: begin
        if (bus_we_i) begin
          err_d = 1'b1;
        end else begin
          err_d = !(|recv_ok);
          if (|recv_ok) rdata_d = REG_W'(recv_sel);
        end
      end
      default: begin
        err_d = bus_req_i;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q           <= '0;
      shadow_q        <= '0;
      bus_rsp_valid_o <= 1'b0;
      bus_rdata_o     <= '0;
      bus_err_o       <= 1'b0;
    end else begin
      bus_rsp_valid_o <= bus_req_i;
      bus_rdata_o     <= rdata_d;
      bus_err_o       <= err_d;
      if (ctrl_wr && (int'(bus_wdata_i[SEL_LSB +: SEL_FW]) < NUM_PORTS))
        sel_q <= SEL_W'(bus_wdata_i[SEL_LSB +: SEL_FW]);
      if (send_wr)
        shadow_q <= bus_wdata_i[DATA_W-1:0];
    end
  end

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i |=> bus_rsp_valid_o); // R10

  AST_RSP_ONLY_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_i |=> !bus_rsp_valid_o); // R10

  AST_SEL_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (NUM_PORTS == 0) || (int'(sel_q) < NUM_PORTS)); // R2

  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_i && bus_we_i && bus_addr_i == ADR_SEND) |=> $stable(shadow_q)); // R5

  AST_ONE_CH_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(send_ok | recv_ok)); // R13

  AST_ERR_DATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rsp_valid_o && bus_err_o) |-> (bus_rdata_o == '0)); // R7

endmodule

// File: tb/sim_dbg_serial_mailbox.sv
module sim_dbg_serial_mailbox;

  localparam int CLK_PERIOD = 10;
  localparam int NPORT = 2;
  localparam int DW = 32;
  localparam logic [6:0] A_CTRL = 7'h34, A_SEND = 7'h35, A_RECV = 7'h36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [6:0] addr = '0;
  logic [31:0] wdata = '0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_data;
  logic [NPORT-1:0] rx_valid, rx_ready, tx_valid, tx_ready;
  logic [NPORT*DW-1:0] rx_data, tx_data;

  logic z_rsp_valid, z_rsp_err, z_rx_valid, z_tx_ready;
  logic [31:0] z_rsp_data, z_rx_data;

  int n_tests = 0;
  int n_fail = 0;
  logic last_err, last_zerr;
  logic [31:0] last_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_serial_mailbox #(.NUM_PORTS(NPORT), .DATA_W(DW), .DEPTH(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rsp_valid_o(rsp_valid), .bus_rdata_o(rsp_data), .bus_err_o(rsp_err),
    .core_rx_valid_o(rx_valid), .core_rx_ready_i(rx_ready), .core_rx_data_o(rx_data),
    .core_tx_valid_i(tx_valid), .core_tx_ready_o(tx_ready), .core_tx_data_i(tx_data)
  );

  dbg_serial_mailbox #(.NUM_PORTS(0), .DATA_W(DW), .DEPTH(4)) u_zero (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rsp_valid_o(z_rsp_valid), .bus_rdata_o(z_rsp_data), .bus_err_o(z_rsp_err),
    .core_rx_valid_o(z_rx_valid), .core_rx_ready_i(1'b0), .core_rx_data_o(z_rx_data),
    .core_tx_valid_i(1'b0), .core_tx_ready_o(z_tx_ready), .core_tx_data_i(32'h0)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    check("R10 response valid", {31'b0, rsp_valid}, 32'd1);
    last_err  = rsp_err;
    last_data = rsp_data;
    last_zerr = z_rsp_err;
  endtask

  task automatic bus_chk(input string tag, input logic w, input logic [6:0] a,
                         input logic [31:0] d, input logic exp_err, input logic [31:0] exp_data);
    bus(w, a, d);
    check({tag, " err"}, {31'b0, last_err}, {31'b0, exp_err});
    if (!w) check({tag, " data"}, last_data, exp_data);
  endtask

  task automatic core_push(input int p, input logic [31:0] d);
    @(negedge clk);
    check("R11 feed ready", {31'b0, tx_ready[p]}, 32'd1);
    tx_valid[p] = 1'b1; tx_data[p*DW +: DW] = d;
    @(negedge clk);
    tx_valid[p] = 1'b0;
  endtask

  task automatic core_pop(input int p, input logic [31:0] d);
    @(negedge clk);
    check("R3 core valid", {31'b0, rx_valid[p]}, 32'd1);
    check("R3 core order", rx_data[p*DW +: DW], d);
    rx_ready[p] = 1'b1;
    @(negedge clk);
    rx_ready[p] = 1'b0;
  endtask

  task automatic t_reset;
    check("R10 idle no response", {31'b0, rsp_valid}, 32'd0);
    check("R1 rx valid", {30'b0, rx_valid}, 32'd0);
    check("R1 tx ready", {30'b0, tx_ready}, 32'd3);
    bus_chk("R1 R2 status", 1'b0, A_CTRL, 0, 1'b0, 32'h0200_0000);
    check("R12 zero channels", {31'b0, last_zerr}, 32'd1);
  endtask

  task automatic t_send_basic;
    bus_chk("R3 send 1", 1'b1, A_SEND, 32'hA1, 1'b0, 0);
    bus_chk("R3 send 2", 1'b1, A_SEND, 32'hA2, 1'b0, 0);
    bus_chk("R5 readback", 1'b0, A_SEND, 0, 1'b0, 32'hA2);
    check("R13 other channel idle", {31'b0, rx_valid[1]}, 32'd0);
    core_pop(0, 32'hA1);
    core_pop(0, 32'hA2);
    check("R11 drained", {31'b0, rx_valid[0]}, 32'd0);
  endtask

  task automatic t_backpressure;
    bus_chk("R3 send", 1'b1, A_SEND, 32'hB0, 1'b0, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R11 hold valid", {31'b0, rx_valid[0]}, 32'd1);
      check("R11 hold data", rx_data[31:0], 32'hB0);
    end
    core_pop(0, 32'hB0);
  endtask

  task automatic t_full;
    for (int i = 0; i < 4; i++) bus_chk("R3 fill", 1'b1, A_SEND, 32'hC0 + i, 1'b0, 0);
    bus_chk("R4 full flag", 1'b0, A_CTRL, 0, 1'b0, 32'h0200_0004);
    bus_chk("R4 overflow refused", 1'b1, A_SEND, 32'hCF, 1'b1, 0);
    bus_chk("R4 error set", 1'b0, A_CTRL, 0, 1'b0, 32'h0200_0005);
    bus_chk("R5 refused write readback", 1'b0, A_SEND, 0, 1'b0, 32'hCF);
    for (int i = 0; i < 4; i++) core_pop(0, 32'hC0 + i);
    check("R4 nothing extra", {31'b0, rx_valid[0]}, 32'd0);
    bus_chk("R4 refused while error", 1'b1, A_SEND, 32'hD0, 1'b1, 0);
    check("R4 nothing queued", {31'b0, rx_valid[0]}, 32'd0);
    bus_chk("R8 write zero", 1'b1, A_CTRL, 32'h0, 1'b0, 0);
    bus_chk("R8 still set", 1'b0, A_CTRL, 0, 1'b0, 32'h0200_0001);
    bus_chk("R8 clear", 1'b1, A_CTRL, 32'h1, 1'b0, 0);
    bus_chk("R8 cleared", 1'b0, A_CTRL, 0, 1'b0, 32'h0200_0000);
  endtask

  task automatic t_recv;
    core_push(0, 32'hE1);
    core_push(0, 32'hE2);
    bus_chk("R6 pending", 1'b0, A_CTRL, 0, 1'b0, 32'h0200_0002);
    bus_chk("R6 first", 1'b0, A_RECV, 0, 1'b0, 32'hE1);
    bus_chk("R6 second", 1'b0, A_RECV, 0, 1'b0, 32'hE2);
    bus_chk("R6 empty status", 1'b0, A_CTRL, 0, 1'b0, 32'h0200_0000);
    bus_chk("R7 underflow", 1'b0, A_RECV, 0, 1'b1, 32'h0);
    core_push(0, 32'hE3);
    bus_chk("R7 refused while error", 1'b0, A_RECV, 0, 1'b1, 32'h0);
    bus_chk("R7 queue intact", 1'b0, A_CTRL, 0, 1'b0, 32'h0200_0003);
    bus_chk("R8 clear", 1'b1, A_CTRL, 32'h1, 1'b0, 0);
    bus_chk("R6 after clear", 1'b0, A_RECV, 0, 1'b0, 32'hE3);
    for (int i = 0; i < 4; i++) core_push(0, 32'hF0 + i);
    @(negedge clk);
    check("R11 feed not ready when full", {31'b0, tx_ready[0]}, 32'd0);
    for (int i = 0; i < 4; i++) bus_chk("R6 drain", 1'b0, A_RECV, 0, 1'b0, 32'hF0 + i);
  endtask

  task automatic t_select;
    bus_chk("R2 select 1", 1'b1, A_CTRL, 32'h0001_0000, 1'b0, 0);
    bus_chk("R2 select readback", 1'b0, A_CTRL, 0, 1'b0, 32'h0201_0000);
    bus_chk("R13 send ch1", 1'b1, A_SEND, 32'h5A, 1'b0, 0);
    check("R13 ch0 untouched", {31'b0, rx_valid[0]}, 32'd0);
    core_pop(1, 32'h5A);
    bus_chk("R13 ch1 underflow", 1'b0, A_RECV, 0, 1'b1, 0);
    bus_chk("R2 ch1 error bit", 1'b0, A_CTRL, 0, 1'b0, 32'h0201_0008);
    bus_chk("R8 clear ch1", 1'b1, A_CTRL, 32'h0001_0008, 1'b0, 0);
    bus_chk("R2 out of range select", 1'b1, A_CTRL, 32'h0002_0000, 1'b0, 0);
    bus_chk("R2 select kept", 1'b0, A_CTRL, 0, 1'b0, 32'h0201_0000);
    bus_chk("R2 select 0", 1'b1, A_CTRL, 32'h0, 1'b0, 0);
  endtask

  task automatic t_readonly;
    core_push(0, 32'h77);
    bus_chk("R9 write refused", 1'b1, A_RECV, 32'h99, 1'b1, 0);
    bus_chk("R9 no side effect", 1'b0, A_CTRL, 0, 1'b0, 32'h0200_0002);
    bus_chk("R9 entry intact", 1'b0, A_RECV, 0, 1'b0, 32'h77);
  endtask

  task automatic t_unmapped;
    bus_chk("R10 unmapped read", 1'b0, 7'h10, 0, 1'b1, 32'h0);
    bus_chk("R10 unmapped write", 1'b1, 7'h37, 32'h1234, 1'b1, 0);
    bus_chk("R10 no error side effect", 1'b0, A_CTRL, 0, 1'b0, 32'h0200_0000);
    check("R12 zero channels send", {31'b0, last_zerr}, 32'd1);
  endtask

  initial begin
    rx_ready = '0; tx_valid = '0; tx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_send_basic();
    t_backpressure();
    t_full();
    t_recv();
    t_select();
    t_readonly();
    t_unmapped();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule